// File: doc/BRIEF.md
# Hybrid Approximate/Accurate Newton Reciprocal Engine

The engine computes the reciprocal of a 16-bit fixed-point divisor with the Newton recurrence x(k+1) = x(k)·(2 − d·x(k)). It finishes one iteration per clock. It has two update units that implement the same step. One uses cheap multipliers that leave out the low partial-product columns. The other uses full-precision multipliers with rounding. A run starts on the cheap unit. After a programmable number of iterations it moves its state to the precise unit, which completes the run. The total iteration count is programmed separately and is never extended to make up for the approximate phase.

Software picks the switch-over index offline for the accuracy it needs. It then issues a start with the divisor, the switch-over index and the total count. When the final iteration is written, `done_o` pulses and `result_o` holds the reciprocal until the next accepted start. The divisor `divisor_i` is unsigned Q0.16 (value = code/65536). The state and the result are unsigned Q2.14 (value = code/16384). Every run begins from the seed parameter `SEED` (default 16'h6000 = 1.5).

Top module: `hybrid_nr_engine`

## Requirements
- R1: After reset `done_o` is 0 and `result_o` is 0.
- R2: An accurate step computes p = (d·x + 2^15) >> 16 and t = max(0, 32768 − p). It yields x' = min(65535, (x·t + 2^13) >> 14), with all products exact.
- R3: An approximate step uses the same formulas without the rounding constants. In both products, every partial-product bit a[j]·b[i] with i + j < 8 is discarded: p = T(d,x) >> 16 and x' = min(65535, T(x,t) >> 14).
- R4: Iteration indices k < N (`approx_iters_i`) use the approximate step and every later index uses the accurate step. The first accurate iteration takes as input the value written by the last approximate iteration.
- R5: A run performs exactly M (`total_iters_i`) iterations, one per cycle. `done_o` is high in the cycle that follows M rising edges after the edge that sampled `start_i`.
- R6: N = 0 gives an all-accurate run, and N ≥ M gives an all-approximate run.
- R7: With M = 0, `done_o` rises in the cycle after the accepting edge and `result_o` equals `SEED`.
- R8: `done_o` is high for exactly one cycle per run. `result_o` does not change from then until the next accepted start.
- R9: A `start_i` that arrives while a run is in progress is ignored. The run ends at its original time with its original result, and no extra `done_o` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Starts a run when the engine is idle |
| divisor_i | input | 16 | Divisor d, unsigned Q0.16, sampled at start |
| approx_iters_i | input | CNT_W | Switch-over index N, sampled at start |
| total_iters_i | input | CNT_W | Total iteration count M, sampled at start |
| done_o | output | 1 | One-cycle pulse after the final iteration |
| result_o | output | 16 | Reciprocal estimate, unsigned Q2.14 |

## Verification
The hardest case to reach from the ports is the handover cycle. There the accurate unit has to consume the approximate unit's last output with no gap, and a fault can only be seen as a small numeric difference in the final result. The stimulus sweeps N across 0, a mid value, exactly M and above M for several divisors. A scoreboard holds a bit-exact model of both step types, so an off-by-one in the switch index, a lost cycle or a wrong operand changes the expected code. A tiny divisor drives the state into saturation. A second start pulsed during a run checks that it is ignored.

// File: rtl/hnr_pkg.sv
package hnr_pkg;
  localparam int unsigned DW   = 16;   // operand width
  localparam int unsigned XF   = 14;   // fraction bits of state
  localparam int unsigned DROP = 8;    // partial-product columns dropped by approx unit
  localparam int unsigned PW   = 2*DW;

  localparam logic [PW-1:0] COL_MASK = {{(PW-DROP){1'b1}}, {DROP{1'b0}}};

  function automatic logic [PW-1:0] drop_mul(input logic [DW-1:0] a, input logic [DW-1:0] b);
    logic [PW-1:0] acc;
    acc = '0;
    for (int i = 0; i < DW; i++)
      if (b[i]) acc = acc + ((PW'(a) << i) & COL_MASK);
    return acc;
  endfunction
endpackage

// File: rtl/hnr_core.sv
module hnr_core
  import hnr_pkg::*;
#(
  parameter bit APPROX = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          ld_d_i,
  input  logic          ld_x_i,
  input  logic [DW-1:0] d_i,
  input  logic [DW-1:0] x_i,
  output logic [DW-1:0] x_o
);
  localparam logic [DW-1:0] TWO  = DW'(1) << (XF + 1);
  localparam logic [PW-1:0] RND1 = PW'(1) << (DW - 1);
  localparam logic [PW-1:0] RND2 = PW'(1) << (XF - 1);

  logic [DW-1:0] d_q, x_q, p, t;
  logic [PW-1:0] m1, m2;

  // operand registers only move when this unit owns the iteration
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      d_q <= '0;
      x_q <= '0;
    end else begin
      if (ld_d_i) d_q <= d_i;
      if (ld_x_i) x_q <= x_i;
    end
  end

  generate
    if (APPROX) begin : g_apx
      assign m1 = drop_mul(d_q, x_q);
      assign m2 = drop_mul(x_q, t);
    end else begin : g_acc
      assign m1 = PW'(d_q) * PW'(x_q) + RND1;
      assign m2 = PW'(x_q) * PW'(t) + RND2;
    end
  endgenerate

  assign p   = m1[PW-1:DW];
  assign t   = (p >= TWO) ? '0 : TWO - p;
  assign x_o = (|m2[PW-1:DW+XF]) ? '1 : m2[DW+XF-1:XF];
endmodule

// File: rtl/hnr_ctrl.sv
module hnr_ctrl #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] n_sw_i,
  input  logic [CNT_W-1:0] n_tot_i,
  output logic             accept_o,
  output logic             busy_o,
  output logic             cur_apx_o,
  output logic             ld_apx_o,
  output logic             ld_acc_o,
  output logic             done_o
);
  logic [CNT_W-1:0] k_q, sw_q, tot_q, k_nx;
  logic             busy_q, done_q, last, more;

  assign accept_o  = start_i && !busy_q;
  assign k_nx      = k_q + 1'b1;
  assign last      = (k_nx == tot_q);
  assign more      = busy_q && !last;
  assign cur_apx_o = (k_q < sw_q);

  // load the unit that owns the next iteration
  always_comb begin
    ld_apx_o = 1'b0;
    ld_acc_o = 1'b0;
    if (accept_o) begin
      if (n_tot_i != '0) begin
        ld_apx_o = (n_sw_i != '0);
        ld_acc_o = (n_sw_i == '0);
      end
    end else if (more) begin
      ld_apx_o = (k_nx < sw_q);
      ld_acc_o = !(k_nx < sw_q);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      k_q    <= '0;
      sw_q   <= '0;
      tot_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (accept_o) begin
        k_q    <= '0;
        sw_q   <= n_sw_i;
        tot_q  <= n_tot_i;
        busy_q <= (n_tot_i != '0);
        done_q <= (n_tot_i == '0);
      end else if (busy_q) begin
        k_q <= k_nx;
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  assign busy_o = busy_q;
  assign done_o = done_q;

  a_r5_count_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> (k_q < tot_q));
  a_r8_done_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !start_i |=> !done_q);
  a_r9_start_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && start_i |=> $stable(tot_q) && $stable(sw_q));
endmodule

// File: rtl/hybrid_nr_engine.sv
module hybrid_nr_engine
  import hnr_pkg::*;
#(
  parameter int unsigned   CNT_W = 8,
  parameter logic [DW-1:0] SEED  = 16'h6000
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW-1:0]    divisor_i,
  input  logic [CNT_W-1:0] approx_iters_i,
  input  logic [CNT_W-1:0] total_iters_i,
  output logic             done_o,
  output logic [DW-1:0]    result_o
);
  logic          accept, busy, cur_apx, ld_apx, ld_acc;
  logic [DW-1:0] apx_x, acc_x, step_x, x_feed, res_q;

  hnr_ctrl #(.CNT_W(CNT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start_i),
    .n_sw_i    (approx_iters_i),
    .n_tot_i   (total_iters_i),
    .accept_o  (accept),
    .busy_o    (busy),
    .cur_apx_o (cur_apx),
    .ld_apx_o  (ld_apx),
    .ld_acc_o  (ld_acc),
    .done_o    (done_o)
  );

  assign step_x = cur_apx ? apx_x : acc_x;
  assign x_feed = accept ? SEED : step_x;  // direct handover, no bubble

  hnr_core #(.APPROX(1'b1)) u_apx (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_d_i (accept),
    .ld_x_i (ld_apx),
    .d_i    (divisor_i),
    .x_i    (x_feed),
    .x_o    (apx_x)
  );

  hnr_core #(.APPROX(1'b0)) u_acc (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ld_d_i (accept),
    .ld_x_i (ld_acc),
    .d_i    (divisor_i),
    .x_i    (x_feed),
    .x_o    (acc_x)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             res_q <= '0;
    else if (accept && total_iters_i == '0) res_q <= SEED;
    else if (busy)                           res_q <= step_x;
  end

  assign result_o = res_q;

  a_r8_result_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !accept |=> $stable(result_o));
  a_r4_idle_apx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && !ld_apx && !accept |=> $stable(apx_x));
  a_r4_one_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({ld_apx, ld_acc}));
endmodule

// File: tb/test_hybrid_nr_engine.sv
module test_hybrid_nr_engine;
  localparam int CW = 8;
  localparam logic [15:0] SEED = 16'h6000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic [15:0]   div = '0;
  logic [CW-1:0] nsw = '0, ntot = '0;
  logic          done;
  logic [15:0]   res;

  int checks = 0, errors = 0;
  int cyc = 0;
  int start_cyc = 0;
  string tag = "";
  logic [15:0] exp_q[$];
  int          lat_q[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  hybrid_nr_engine #(.CNT_W(CW), .SEED(SEED)) i_hybrid_nr_engine (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .divisor_i(div),
    .approx_iters_i(nsw), .total_iters_i(ntot), .done_o(done), .result_o(res));

  task automatic chk(input string r, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", r, tag, act, exp);
    end
  endtask

  // bit-level model of the column-dropping multiplier (R3)
  function automatic longint tmul(input longint a, input longint b);
    longint s = 0;
    for (int i = 0; i < 16; i++)
      for (int j = 0; j < 16; j++)
        if (b[i] && a[j] && (i + j >= 8)) s += longint'(1) << (i + j);
    return s;
  endfunction

  function automatic longint step(input longint d, input longint x, input bit apx);
    longint p, t, q;
    p = apx ? (tmul(d, x) >> 16) : ((d * x + 32768) >> 16);
    t = (p >= 32768) ? 0 : 32768 - p;
    q = apx ? (tmul(x, t) >> 14) : ((x * t + 8192) >> 14);
    return (q > 65535) ? 65535 : q;
  endfunction

  function automatic logic [15:0] model(input longint d, input int n, input int m);
    longint x = SEED;
    for (int k = 0; k < m; k++) x = step(d, x, k < n);
    return x[15:0];
  endfunction

  // monitor: pops expected result and latency on each done pulse
  always @(negedge clk) begin
    if (rst_n && done) begin
      if (exp_q.size() == 0) chk("R9", 1, 0);
      else begin
        chk(tag, res, exp_q.pop_front());
        chk("R5", cyc - start_cyc, lat_q.pop_front());
      end
    end
  end

  task automatic run(input string r, input logic [15:0] d, input int n, input int m, input bit poke);
    logic [15:0] e;
    e = model(d, n, m);
    exp_q.push_back(e);
    lat_q.push_back(m);
    @(negedge clk);
    tag = r;
    div = d; nsw = CW'(n); ntot = CW'(m); start = 1'b1;
    start_cyc = cyc + 1;
    @(negedge clk);
    start = 1'b0;
    if (poke && m >= 3) begin
      div = 16'h1234; nsw = 0; ntot = 2; start = 1'b1;  // R9 interfering start
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk("R8", done, 0);
    repeat (3) @(negedge clk);
    chk("R8", res, e);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", done, 0);
    chk("R1", res, 0);
    rst_n = 1'b1;
    run("R2", 16'h8000, 0, 6, 0);
    run("R6", 16'h8000, 6, 6, 0);
    run("R3", 16'hC000, 5, 5, 0);
    run("R4", 16'hC000, 3, 6, 0);
    run("R4", 16'hAAAA, 2, 5, 0);
    run("R6", 16'hFFFF, 10, 4, 0);
    run("R7", 16'h9000, 0, 0, 0);
    run("R9", 16'hB000, 1, 7, 1);
    run("R6", 16'hE000, 4, 1, 0);
    run("R2", 16'h0001, 2, 8, 0);
    run("R4", 16'hD555, 1, 2, 0);
    repeat (4) @(negedge clk);
    chk("R9", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule